// File: doc/BRIEF.md
# Channel Program Sequencer

This block is a small input/output channel engine that runs a stored program of command words without help from the host. The host writes the byte address of the first command word to `prog_addr` and pulses `start`. From then on the engine fetches each 8-byte command word over a byte-wide synchronous memory port. It executes the word and moves on to the next one until the program ends. At the end it raises a one-cycle completion interrupt and leaves a result code on `status`.

There are three device commands: transfers from memory to the device, transfers from the device to memory, and a positioning command. The engine carries out every device handshake itself and moves data one byte per handshake. A branch command redirects fetching to another address without touching the device. A per-command flag lets the device's status-modifier indication skip the following command word. This gives a program a way to take an alternate path, for example on an error, with no host involvement.

Top module: `chprog_engine`

## Requirements
- R1: `start` is accepted only while `busy` is low. When it is accepted, `busy` rises on the next edge and the first memory read is issued to `prog_addr`. A `start` that arrives while `busy` is high has no effect on the running program.
- R2: A command word occupies 8 consecutive bytes, read in ascending address order. Byte 0 is the opcode. Byte 1 holds the flags: bit 0 is chain and bit 1 is skip-on-modifier. Bytes 2–3 hold the 16-bit byte count, low byte first. Bytes 4–7 hold the 32-bit data address, low byte first, and only its low address-width bits are used.
- R3: Opcode 0x01 (output) reads `count` bytes from memory, starting at the data address and going upward. Each byte is presented on `dev_wdata` with `dev_op` = 1, one handshake per byte.
- R4: Opcode 0x02 (input) performs `count` handshakes with `dev_op` = 2. The `dev_rdata` byte returned by each handshake is written to memory at the data address, which then increments.
- R5: Opcode 0x03 (position) performs exactly one handshake with `dev_op` = 3. `dev_arg` carries the count field, and no memory data access takes place. `dev_arg` also carries the count field during the handshakes of opcodes 0x01 and 0x02.
- R6: Opcode 0x08 (branch) makes the data address the next fetch address. It performs no handshake and no data access.
- R7: The command executed with its chain bit clear is the last one. The engine then sets `status` = 0, pulses `irq` high for exactly one cycle and drops `busy` in the same cycle.
- R8: If the skip flag of a device command is set and `dev_mod` was high at any acknowledge of that command, the next fetch address is the current word's address plus 16 instead of plus 8.
- R9: `dev_err` high at an acknowledge ends the program at once, with `status` = 1 and an `irq` pulse. No memory write is made for that byte.
- R10: Any opcode other than 0x01, 0x02, 0x03 and 0x08 ends the program with `status` = 2 and an `irq` pulse, without any handshake.
- R11: An output or input command with a count of zero performs no handshake and no data access, and the program continues with the next word.
- R12: `dev_req` rises with `dev_op`, `dev_wdata` and `dev_arg` valid and holds them stable until `dev_ack` is sampled high. It falls on the edge after that. Only one request is outstanding at a time, and no memory access is issued while it is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe from the host |
| prog_addr | input | AW | Byte address of the first command word |
| busy | output | 1 | High while a program is running |
| irq | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result of the last program: 0 ok, 1 device error, 2 bad opcode |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable (read when low) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the access edge |
| dev_req | output | 1 | Device request |
| dev_op | output | 2 | Device operation: 1 output, 2 input, 3 position |
| dev_wdata | output | 8 | Byte sent to the device |
| dev_arg | output | 16 | Count field of the current command |
| dev_ack | input | 1 | Device acknowledge |
| dev_rdata | input | 8 | Byte returned by the device on acknowledge |
| dev_err | input | 1 | Device error, sampled with `dev_ack` |
| dev_mod | input | 1 | Status-modifier indication, sampled with `dev_ack` |

## Verification
The bench builds the engine with AW = 10, so the memory model is 1 KiB. Its full contents can then be compared after every program against an image that a bench interpreter produces from the same starting contents. With this size, programs sit low in memory and data buffers sit high. Fetches that a skip carries past the end of a program land on filler bytes that are invalid opcodes, so random skip patterns reach the bad-opcode path without special setup. Device acknowledges come after random delays of 0 to 2 cycles, and modifier and error indications are placed at chosen handshake numbers, so the skip, error and hold-until-acknowledge rules are exercised at varying offsets.

// File: rtl/chp_pkg.sv
package chp_pkg;

  localparam logic [7:0] OPC_OUT    = 8'h01;
  localparam logic [7:0] OPC_IN     = 8'h02;
  localparam logic [7:0] OPC_POS    = 8'h03;
  localparam logic [7:0] OPC_BRANCH = 8'h08;

  localparam int FLAG_CHAIN = 0;
  localparam int FLAG_SKIP  = 1;

  localparam logic [1:0] RES_OK     = 2'd0;
  localparam logic [1:0] RES_DEVERR = 2'd1;
  localparam logic [1:0] RES_BADOP  = 2'd2;

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] count;
    logic [7:0]  flags;
    logic [7:0]  opcode;
  } cmd_word_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_MREQ,
    S_MWAIT,
    S_MCAP,
    S_DECODE,
    S_HGO,
    S_HWAIT,
    S_NEXT
  } seq_state_e;

endpackage

// File: rtl/chp_word_asm.sv
module chp_word_asm #(
  parameter int NBYTES = 8
) (
  input  logic                      clk,
  input  logic                      ld,
  input  logic [$clog2(NBYTES)-1:0] idx,
  input  logic [7:0]                din,
  output logic [NBYTES*8-1:0]       word
);

  localparam int IW = $clog2(NBYTES);

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (ld && idx == IW'(g)) lane_q <= din;
    end
    assign word[g*8 +: 8] = lane_q;
  end

endmodule

// File: rtl/chp_dev_hs.sv
module chp_dev_hs #(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [1:0]    op_in,
  input  logic [DW-1:0] wdata_in,
  input  logic [CW-1:0] arg_in,
  input  logic          dev_ack,
  input  logic [DW-1:0] dev_rdata,
  input  logic          dev_err,
  input  logic          dev_mod,
  output logic          dev_req,
  output logic [1:0]    dev_op,
  output logic [DW-1:0] dev_wdata,
  output logic [CW-1:0] dev_arg,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic          mod
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_req   <= 1'b0;
      dev_op    <= 2'd0;
      dev_wdata <= '0;
      dev_arg   <= '0;
      done      <= 1'b0;
      rdata     <= '0;
      err       <= 1'b0;
      mod       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!dev_req) begin
        if (go) begin
          dev_req   <= 1'b1;
          dev_op    <= op_in;
          dev_wdata <= wdata_in;
          dev_arg   <= arg_in;
        end
      end else if (dev_ack) begin
        dev_req <= 1'b0;
        done    <= 1'b1;
        rdata   <= dev_rdata;
        err     <= dev_err;
        mod     <= dev_mod;
      end
    end
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
    dev_req && !dev_ack |=> dev_req && $stable(dev_op) && $stable(dev_wdata) && $stable(dev_arg))
    else $error("request changed before acknowledge");

  p_req_drop_r12: assert property (@(posedge clk) disable iff (rst)
    dev_req && dev_ack |=> !dev_req)
    else $error("request stayed high after acknowledge");

  p_done_follows_ack_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(dev_req && dev_ack))
    else $error("completion without acknowledge");

endmodule

// File: rtl/chprog_engine.sv
module chprog_engine
  import chp_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] prog_addr,
  output logic          busy,
  output logic          irq,
  output logic [1:0]    status,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          dev_req,
  output logic [1:0]    dev_op,
  output logic [7:0]    dev_wdata,
  output logic [15:0]   dev_arg,
  input  logic          dev_ack,
  input  logic [7:0]    dev_rdata,
  input  logic          dev_err,
  input  logic          dev_mod
);

  localparam int WORD_BYTES = 8;
  localparam int BIW        = $clog2(WORD_BYTES);
  localparam int CNT_W      = 16;
  localparam logic [AW-1:0] STEP_ONE = AW'(WORD_BYTES);
  localparam logic [AW-1:0] STEP_TWO = AW'(2 * WORD_BYTES);

  seq_state_e        st;
  logic [AW-1:0]     fptr;
  logic [AW-1:0]     dptr;
  logic [BIW-1:0]    bidx;
  logic [CNT_W-1:0]  remain;
  logic              mod_seen;
  logic              fetching;
  logic [7:0]        xbyte;

  logic [WORD_BYTES*8-1:0] word_raw;
  cmd_word_t               cw;
  logic                    hs_done;
  logic [7:0]              hs_rdata;
  logic                    hs_err;
  logic                    hs_mod;

  assign cw = cmd_word_t'(word_raw);

  chp_word_asm #(.NBYTES(WORD_BYTES)) u_asm (
    .clk  (clk),
    .ld   (st == S_MCAP && fetching),
    .idx  (bidx),
    .din  (mem_rdata),
    .word (word_raw)
  );

  chp_dev_hs #(.DW(8), .CW(CNT_W)) u_hs (
    .clk       (clk),
    .rst       (rst),
    .go        (st == S_HGO),
    .op_in     (cw.opcode[1:0]),
    .wdata_in  (xbyte),
    .arg_in    (cw.count),
    .dev_ack   (dev_ack),
    .dev_rdata (dev_rdata),
    .dev_err   (dev_err),
    .dev_mod   (dev_mod),
    .dev_req   (dev_req),
    .dev_op    (dev_op),
    .dev_wdata (dev_wdata),
    .dev_arg   (dev_arg),
    .done      (hs_done),
    .rdata     (hs_rdata),
    .err       (hs_err),
    .mod       (hs_mod)
  );

  if (AW < 32) begin : g_addr_hi
    logic addr_hi_unused;
    assign addr_hi_unused = ^cw.addr[31:AW];
  end
  logic flags_unused;
  assign flags_unused = ^cw.flags[7:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      busy      <= 1'b0;
      irq       <= 1'b0;
      status    <= RES_OK;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      fptr      <= '0;
      dptr      <= '0;
      bidx      <= '0;
      remain    <= '0;
      mod_seen  <= 1'b0;
      fetching  <= 1'b0;
      xbyte     <= '0;
    end else begin
      irq    <= 1'b0;
      mem_en <= 1'b0;
      mem_we <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            fptr     <= prog_addr;
            bidx     <= '0;
            fetching <= 1'b1;
            busy     <= 1'b1;
            st       <= S_MREQ;
          end
        end
        S_MREQ: begin
          mem_en   <= 1'b1;
          mem_addr <= fetching ? fptr + AW'(bidx) : dptr;
          st       <= S_MWAIT;
        end
        S_MWAIT: st <= S_MCAP;
        S_MCAP: begin
          if (fetching) begin
            if (bidx == BIW'(WORD_BYTES - 1)) begin
              st <= S_DECODE;
            end else begin
              bidx <= bidx + 1'b1;
              st   <= S_MREQ;
            end
          end else begin
            xbyte <= mem_rdata;
            st    <= S_HGO;
          end
        end
        S_DECODE: begin
          fetching <= 1'b0;
          mod_seen <= 1'b0;
          dptr     <= cw.addr[AW-1:0];
          remain   <= cw.count;
          case (cw.opcode)
            OPC_BRANCH: begin
              fptr <= cw.addr[AW-1:0];
              st   <= S_NEXT;
            end
            OPC_OUT: st <= (cw.count == '0) ? S_NEXT : S_MREQ;
            OPC_IN:  st <= (cw.count == '0) ? S_NEXT : S_HGO;
            OPC_POS: st <= S_HGO;
            default: begin
              status <= RES_BADOP;
              irq    <= 1'b1;
              busy   <= 1'b0;
              st     <= S_IDLE;
            end
          endcase
        end
        S_HGO: st <= S_HWAIT;
        S_HWAIT: begin
          if (hs_done) begin
            if (hs_err) begin
              status <= RES_DEVERR;
              irq    <= 1'b1;
              busy   <= 1'b0;
              st     <= S_IDLE;
            end else begin
              mod_seen <= mod_seen | hs_mod;
              if (cw.opcode == OPC_POS) begin
                st <= S_NEXT;
              end else begin
                if (cw.opcode == OPC_IN) begin
                  mem_en    <= 1'b1;
                  mem_we    <= 1'b1;
                  mem_addr  <= dptr;
                  mem_wdata <= hs_rdata;
                end
                dptr   <= dptr + 1'b1;
                remain <= remain - 1'b1;
                if (remain == CNT_W'(1)) st <= S_NEXT;
                else st <= (cw.opcode == OPC_IN) ? S_HGO : S_MREQ;
              end
            end
          end
        end
        S_NEXT: begin
          if (!cw.flags[FLAG_CHAIN]) begin
            status <= RES_OK;
            irq    <= 1'b1;
            busy   <= 1'b0;
            st     <= S_IDLE;
          end else begin
            if (cw.opcode != OPC_BRANCH)
              fptr <= fptr + ((cw.flags[FLAG_SKIP] && mod_seen) ? STEP_TWO : STEP_ONE);
            bidx     <= '0;
            fetching <= 1'b1;
            st       <= S_MREQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_en && !dev_req)
    else $error("activity while idle");

  p_fetch_after_start_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> mem_en && !mem_we)
    else $error("no fetch after start");

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq)
    else $error("completion pulse longer than one cycle");

  p_irq_not_busy_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> !busy)
    else $error("busy still high at completion");

  p_no_mem_during_req_r12: assert property (@(posedge clk) disable iff (rst)
    dev_req |-> !mem_en)
    else $error("memory access during device request");

endmodule

// File: tb/tb_chprog_engine.sv
module tb_chprog_engine;

  localparam int AW   = 10;
  localparam int MEMN = 1 << AW;
  localparam int MSK  = MEMN - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic busy, irq;
  logic [1:0] status;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic dev_req;
  logic [1:0] dev_op;
  logic [7:0] dev_wdata;
  logic [15:0] dev_arg;
  logic dev_ack = 1'b0;
  logic [7:0] dev_rdata = '0;
  logic dev_err = 1'b0;
  logic dev_mod = 1'b0;

  always #10 clk = ~clk;

  chprog_engine #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .start(start), .prog_addr(prog_addr),
    .busy(busy), .irq(irq), .status(status),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_req(dev_req), .dev_op(dev_op), .dev_wdata(dev_wdata), .dev_arg(dev_arg),
    .dev_ack(dev_ack), .dev_rdata(dev_rdata), .dev_err(dev_err), .dev_mod(dev_mod)
  );

  logic [7:0] mem  [MEMN];
  logic [7:0] rmem [MEMN];
  int rd_cnt, wr_cnt, first_addr;
  bit first_seen;

  bit mod_bits [256];
  int err_at;
  int hs_cnt, dly;
  int l_op [256];
  int l_wd [256];
  int l_arg[256];
  int e_op [256];
  int e_wd [256];
  int e_arg[256];
  int e_n, e_rd, e_wr, e_status;

  int checks = 0;
  int fails  = 0;

  function automatic int dev_byte(input int k);
    return (k * 37 + 11) & 255;
  endfunction

  // memory model: synchronous byte port, read data one cycle after the access edge
  initial begin
    forever begin
      @(posedge clk);
      if (mem_en) begin
        if (!first_seen) begin
          first_addr = int'(mem_addr);
          first_seen = 1'b1;
        end
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata = mem[mem_addr];
          rd_cnt++;
        end
      end
    end
  end

  // device model: acknowledges after 0..2 cycles, logs each handshake
  initial begin
    dly = 0;
    forever begin
      @(negedge clk);
      if (dev_ack) begin
        dev_ack = 1'b0;
        dev_err = 1'b0;
        dev_mod = 1'b0;
      end else if (dev_req) begin
        if (dly > 0) dly--;
        else begin
          if (hs_cnt < 256) begin
            l_op[hs_cnt]  = int'(dev_op);
            l_wd[hs_cnt]  = int'(dev_wdata);
            l_arg[hs_cnt] = int'(dev_arg);
            dev_mod = mod_bits[hs_cnt];
          end
          dev_rdata = 8'(dev_byte(hs_cnt));
          dev_err   = (hs_cnt == err_at);
          dev_ack   = 1'b1;
          hs_cnt++;
          dly = int'($urandom % 3);
        end
      end
    end
  end

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary_and_end();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put_cmd(input int at, input int op, input int fl, input int cnt, input int ad);
    mem[(at + 0) & MSK] = 8'(op);
    mem[(at + 1) & MSK] = 8'(fl);
    mem[(at + 2) & MSK] = 8'(cnt);
    mem[(at + 3) & MSK] = 8'(cnt >> 8);
    mem[(at + 4) & MSK] = 8'(ad);
    mem[(at + 5) & MSK] = 8'(ad >> 8);
    mem[(at + 6) & MSK] = 8'(ad >> 16);
    mem[(at + 7) & MSK] = 8'(ad >> 24);
  endtask

  task automatic prep_image();
    for (int i = 0; i < MEMN; i++) mem[i] = (i < 512) ? 8'hFF : 8'($urandom);
    for (int i = 0; i < 256; i++) mod_bits[i] = 1'b0;
    err_at = -1;
  endtask

  // interpreter written from the requirements
  task automatic ref_model(input int pa);
    int pc, hs, ncmd;
    bit fin;
    for (int i = 0; i < MEMN; i++) rmem[i] = mem[i];
    pc = pa; hs = 0; ncmd = 0; fin = 0;
    e_rd = 0; e_wr = 0; e_status = 0;
    while (!fin && ncmd < 64) begin
      int op, fl, cnt, ad;
      bit modf;
      op  = int'(rmem[pc & MSK]);
      fl  = int'(rmem[(pc + 1) & MSK]);
      cnt = int'(rmem[(pc + 2) & MSK]) | (int'(rmem[(pc + 3) & MSK]) << 8);
      ad  = int'(rmem[(pc + 4) & MSK]) | (int'(rmem[(pc + 5) & MSK]) << 8);
      e_rd += 8;
      ncmd++;
      modf = 0;
      if (op == 8) begin
        pc = ad & MSK;
      end else if (op == 1 || op == 2) begin
        for (int k = 0; k < cnt && !fin; k++) begin
          if (op == 1) e_rd++;
          e_op[hs]  = op;
          e_wd[hs]  = (op == 1) ? int'(rmem[ad & MSK]) : 0;
          e_arg[hs] = cnt;
          if (hs == err_at) begin
            e_status = 1;
            fin = 1;
          end else begin
            modf |= mod_bits[hs];
            if (op == 2) begin
              rmem[ad & MSK] = 8'(dev_byte(hs));
              e_wr++;
            end
            ad++;
          end
          hs++;
        end
      end else if (op == 3) begin
        e_op[hs] = 3; e_wd[hs] = 0; e_arg[hs] = cnt;
        if (hs == err_at) begin
          e_status = 1;
          fin = 1;
        end else modf = mod_bits[hs];
        hs++;
      end else begin
        e_status = 2;
        fin = 1;
      end
      if (!fin) begin
        if ((fl & 1) == 0) fin = 1;
        else if (op != 8) pc = (pc + ((((fl & 2) != 0) && modf) ? 16 : 8)) & MSK;
      end
    end
    e_n = hs;
  endtask

  task automatic run_prog(input int pa, input bit poke_start);
    int cyc, bad, bad_at;
    ref_model(pa);
    hs_cnt = 0; rd_cnt = 0; wr_cnt = 0; first_seen = 0;
    @(negedge clk);
    prog_addr = AW'(pa);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_start) begin
      repeat (5) @(negedge clk);
      chk(busy == 1'b1, "R1", "busy during run", int'(busy), 1);
      prog_addr = AW'(pa ^ 'h1C0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!irq && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    if (!irq) begin
      checks++;
      fails++;
      $display("FAIL R7 completion: actual timeout expected irq");
      summary_and_end();
    end
    chk(int'(status) == e_status, "R7", "status at completion", int'(status), e_status);
    @(negedge clk);
    chk(!irq && !busy, "R7", "irq one cycle, busy low", int'({irq, busy}), 0);
    chk(first_addr == pa, "R1", "first fetch address", first_addr, pa);
    chk(hs_cnt == e_n, "R12", "handshake count", hs_cnt, e_n);
    bad = 0; bad_at = 0;
    for (int i = 0; i < e_n && i < hs_cnt; i++) begin
      if (!bad && (l_op[i] != e_op[i] || l_arg[i] != e_arg[i] ||
                   (e_op[i] == 1 && l_wd[i] != e_wd[i]))) begin
        bad = 1;
        bad_at = i;
      end
    end
    chk(!bad, "R3", "handshake op/data/arg (index)", bad_at, -1);
    bad = 0; bad_at = 0;
    for (int i = 0; i < MEMN; i++)
      if (!bad && mem[i] !== rmem[i]) begin
        bad = 1;
        bad_at = i;
      end
    chk(!bad, "R4", "memory image (address)", bad_at, -1);
    chk(rd_cnt == e_rd, "R2", "memory read count", rd_cnt, e_rd);
    chk(wr_cnt == e_wr, "R11", "memory write count", wr_cnt, e_wr);
  endtask

  initial begin
    void'($urandom(32'h5EED_0C0D));
    err_at = -1;
    hs_cnt = 0;
    for (int i = 0; i < MEMN; i++) mem[i] = 8'hFF;
    for (int i = 0; i < 256; i++) mod_bits[i] = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !irq && !dev_req && !mem_en && status == 2'd0, "R1", "reset state",
        int'({busy, irq, dev_req, mem_en, status}), 0);

    // R6: branch over an invalid word
    prep_image();
    put_cmd('h000, 8, 1, 0, 'h100);
    put_cmd('h100, 1, 0, 3, 'h210);
    run_prog('h000, 0);
    chk(int'(status) == 0 && hs_cnt == 3, "R6", "branch target executed", hs_cnt, 3);

    // R8: skip taken on modifier
    prep_image();
    mod_bits[0] = 1'b1;
    put_cmd('h020, 3, 3, 'h55, 0);
    put_cmd('h028, 8'hEE, 1, 0, 0);
    put_cmd('h030, 1, 0, 2, 'h220);
    run_prog('h020, 0);
    chk(int'(status) == 0 && hs_cnt == 3, "R8", "skip over next word", int'(status), 0);
    chk(l_op[0] == 3 && l_arg[0] == 'h55, "R5", "position argument", l_arg[0], 'h55);

    // R8 without modifier: the invalid word runs
    prep_image();
    put_cmd('h020, 3, 3, 'h55, 0);
    put_cmd('h028, 8'hEE, 1, 0, 0);
    put_cmd('h030, 1, 0, 2, 'h220);
    run_prog('h020, 0);
    chk(int'(status) == 2, "R8", "no skip without modifier", int'(status), 2);

    // R9: device error on the third input byte
    prep_image();
    err_at = 2;
    put_cmd('h040, 2, 1, 5, 'h240);
    put_cmd('h048, 1, 0, 1, 'h260);
    run_prog('h040, 0);
    chk(int'(status) == 1 && wr_cnt == 2, "R9", "error stops input", wr_cnt, 2);

    // R10: invalid opcode first
    prep_image();
    put_cmd('h060, 7, 1, 4, 'h200);
    run_prog('h060, 0);
    chk(int'(status) == 2 && hs_cnt == 0, "R10", "bad opcode no handshake", hs_cnt, 0);

    // R11: zero count, then one input byte; R1: start while busy ignored
    prep_image();
    put_cmd('h080, 1, 1, 0, 'h250);
    put_cmd('h088, 2, 0, 1, 'h250);
    run_prog('h080, 1);
    chk(int'(status) == 0 && hs_cnt == 1 && int'(mem['h250]) == dev_byte(0), "R11",
        "zero count skipped", int'(mem['h250]), dev_byte(0));

    // random programs
    for (int t = 0; t < 40; t++) begin
      int n;
      prep_image();
      n = 1 + int'($urandom % 6);
      for (int i = 0; i < n; i++) begin
        int sel, op, cnt;
        sel = int'($urandom % 4);
        op  = (sel == 3) ? 3 : ((sel == 2) ? 2 : 1);
        cnt = int'($urandom % 7);
        put_cmd(i * 8, op, ((i != n - 1) ? 1 : 0) | (int'($urandom % 2) << 1),
                cnt, 'h200 + int'($urandom % 'h1F0));
      end
      for (int i = 0; i < 64; i++) mod_bits[i] = ($urandom % 4) == 0;
      err_at = (($urandom % 5) == 0) ? int'($urandom % 20) : -1;
      run_prog(0, (t % 8) == 0);
    end

    summary_and_end();
  end

endmodule